// File: doc/BRIEF.md
# Timed Serial Flash Word Reader

This block is a register-driven serial flash master that fetches one 32-bit word from a 24-bit flash address. Software loads an address register and a control word. The control word carries five per-phase durations, an instruction selector and a wait-ready flag. Software then writes the control word a second time with its start bit set. The engine lowers chip select and shifts out a command byte taken from a small opcode register file, followed by the address. It then shifts in the data word and writes it to a data register. The start bit clears by itself once the word is ready.

All waveform phases are counted in system clock cycles: the chip-select lead-in, the clock-high time, the clock-low time, the chip-select tail and the chip-select idle gap. A field value of zero behaves as one. The serial interface runs in mode 0. Clock idles low, outgoing bits change only while the clock is low, and incoming bits are taken on the rising clock. After every frame, chip select stays high for the programmed idle gap before another frame can begin. While a transfer or its idle gap is in progress, the engine discards all register writes.

Top module: `spi_word_reader`

## Requirements
- R1: After reset, chip select is high and the serial clock is low. The control register reads 0x00132222: lead-in 2 in bits 3:0, clock-high 2 in bits 7:4, clock-low 2 in bits 11:8, tail 2 in bits 15:12, idle gap 3 in bits 19:16, selector 1 in bits 22:20, wait-ready 0 in bit 23, start 0 in bit 31. Opcode slot 1 (register address 9) reads 0x03, opcode slot 0 (address 8) reads 0, and the address register (address 0) and data register (address 2) read 0.
- R2: A frame is the selected 8-bit opcode, then the 24 address bits, both MSB first on the output line, then 32 data bits taken MSB first from the input line on rising clock edges. The output line does not change while the clock is high.
- R3: Chip select stays low for exactly lead + 64*(low+high) + tail cycles. The first rising clock comes lead + low cycles after chip select falls. The clock is high for 64*high cycles in total, and exactly 64 rising edges occur. Chip select rises tail cycles after the last falling clock.
- R4: A duration field of 0 gives the same timing as a value of 1.
- R5: Writing the control register (address 1) with bit 31 set while idle sets start at that clock edge. Chip select falls at the next edge.
- R6: With wait-ready 0, start clears on the same edge that chip select rises. With wait-ready 1, start clears only after chip select has been high for the idle-gap count.
- R7: The data register holds the received word when start reads 0, and software can overwrite it (for example to clear it) while idle.
- R8: Writes to any register are ignored while start is set or a frame or its idle gap is in progress.
- R9: If a start write is attempted on every cycle, chip select stays high for exactly idle-gap + 2 cycles between two frames.
- R10: Register addresses 8 to 15 hold eight writable, readable opcode slots, indexed by address bits 2:0. The selector field picks which slot supplies the command byte.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one timing unit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
Two things can meet in one cycle: the engine finishing a frame and clearing start, and software writing a new start. To provoke this, the bench writes a start command on every cycle right after completion, with both settings of the wait-ready flag. The write that lands inside the idle gap must be dropped, and only the first write after the gap may launch a frame. This is judged from the pins: chip select must stay high for exactly the gap count plus two cycles, and the read-back start bit must stay clear during the gap.

// File: rtl/spi_rd_pkg.sv
`timescale 1ns/1ps
package spi_rd_pkg;

   localparam int TW      = 4;
   localparam int SEL_W   = 3;
   localparam int NUM_OPS = 1 << SEL_W;
   localparam int REG_AW  = 4;
   localparam int RSVD_W  = 32 - 2 - SEL_W - 5 * TW;

   typedef struct packed {
      logic              start;
      logic [RSVD_W-1:0] rsvd;
      logic              wait_rdy;
      logic [SEL_W-1:0]  sel;
      logic [TW-1:0]     cs_gap;
      logic [TW-1:0]     cs_tail;
      logic [TW-1:0]     sck_lo;
      logic [TW-1:0]     sck_hi;
      logic [TW-1:0]     cs_lead;
   } ctrl_t;

   localparam ctrl_t CTRL_RST = '{start: 1'b0, rsvd: '0, wait_rdy: 1'b0,
                                  sel: 3'd1, cs_gap: 4'd3, cs_tail: 4'd2,
                                  sck_lo: 4'd2, sck_hi: 4'd2, cs_lead: 4'd2};

   localparam logic [REG_AW-1:0] A_ADDR = 4'd0;
   localparam logic [REG_AW-1:0] A_CTRL = 4'd1;
   localparam logic [REG_AW-1:0] A_DATA = 4'd2;

   typedef enum logic [2:0] {
      PH_IDLE, PH_LEAD, PH_LOW, PH_HIGH, PH_TAIL, PH_GAP
   } phase_e;

   function automatic logic [TW-1:0] at_least_one(input logic [TW-1:0] v);
      return (v == '0) ? TW'(1) : v;
   endfunction

endpackage

// File: rtl/spi_rd_regs.sv
`timescale 1ns/1ps
module spi_rd_regs
   import spi_rd_pkg::*;
#(
   parameter int ADDR_BITS   = 24,
   parameter int DATA_BITS   = 32,
   parameter int OP_BITS     = 8,
   parameter int READ_SLOT   = 1,
   parameter logic [OP_BITS-1:0] READ_OPCODE = 8'h03
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [REG_AW-1:0]    wr_addr,
   input  logic [31:0]          wr_data,
   input  logic [REG_AW-1:0]    rd_addr,
   output logic [31:0]          rd_data,
   input  logic                 eng_busy,
   input  logic                 done_clr,
   input  logic                 cap_we,
   input  logic [DATA_BITS-1:0] cap_data,
   output ctrl_t                cfg,
   output logic [ADDR_BITS-1:0] flash_addr,
   output logic [OP_BITS-1:0]   opcode
);

   ctrl_t                 ctrl_q;
   ctrl_t                 ctrl_wr;
   logic [ADDR_BITS-1:0]  addr_q;
   logic [DATA_BITS-1:0]  data_q;
   logic [OP_BITS-1:0]    op_arr [NUM_OPS];
   logic                  locked;
   logic                  wr_ok;
   logic                  op_win;

   assign locked = ctrl_q.start | eng_busy;
   assign wr_ok  = wr_en & ~locked;
   assign op_win = wr_addr[REG_AW-1];

   always_comb begin
      ctrl_wr      = ctrl_t'(wr_data);
      ctrl_wr.rsvd = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RST;
      end else if (done_clr) begin
         ctrl_q.start <= 1'b0;
      end else if (wr_ok && !op_win && wr_addr == A_CTRL) begin
         ctrl_q <= ctrl_wr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (wr_ok && !op_win && wr_addr == A_ADDR) begin
         addr_q <= wr_data[ADDR_BITS-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (cap_we) begin
         data_q <= cap_data;
      end else if (wr_ok && !op_win && wr_addr == A_DATA) begin
         data_q <= wr_data[DATA_BITS-1:0];
      end
   end

   for (genvar i = 0; i < NUM_OPS; i++) begin : g_slot
      localparam logic [OP_BITS-1:0] RST_VAL = (i == READ_SLOT) ? READ_OPCODE : '0;
      logic [OP_BITS-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_q <= RST_VAL;
         end else if (wr_ok && op_win && wr_addr[SEL_W-1:0] == SEL_W'(i)) begin
            slot_q <= wr_data[OP_BITS-1:0];
         end
      end
      assign op_arr[i] = slot_q;
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr[REG_AW-1]) begin
         rd_data = 32'(op_arr[rd_addr[SEL_W-1:0]]);
      end else begin
         case (rd_addr)
            A_ADDR:  rd_data = 32'(addr_q);
            A_CTRL:  rd_data = ctrl_q;
            A_DATA:  rd_data = 32'(data_q);
            default: rd_data = '0;
         endcase
      end
   end

   assign cfg        = ctrl_q;
   assign flash_addr = addr_q;
   assign opcode     = op_arr[ctrl_q.sel];

   // R8: a register is frozen across any cycle that began locked
   p_addr_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(addr_q));

   // R6: only the engine can drop the start bit
   p_start_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.start && !done_clr) |=> ctrl_q.start);

endmodule

// File: rtl/spi_rd_timer.sv
`timescale 1ns/1ps
module spi_rd_timer #(
   parameter int TW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] len,
   output logic          last,
   output logic          empty
);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= len;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign last  = (cnt_q == TW'(1));
   assign empty = (cnt_q == '0);

   // R4: a phase is never loaded with a zero length
   p_len_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (len != '0));

endmodule

// File: rtl/spi_rd_seq.sv
`timescale 1ns/1ps
module spi_rd_seq
   import spi_rd_pkg::*;
#(
   parameter int ADDR_BITS = 24,
   parameter int DATA_BITS = 32,
   parameter int OP_BITS   = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  ctrl_t                cfg,
   input  logic [OP_BITS-1:0]   opcode,
   input  logic [ADDR_BITS-1:0] flash_addr,
   input  logic                 miso,
   input  logic                 t_last,
   output logic                 t_load,
   output logic [TW-1:0]        t_len,
   output logic                 cs_n,
   output logic                 sck,
   output logic                 mosi,
   output logic                 eng_busy,
   output logic                 done_clr,
   output logic                 cap_we,
   output logic [DATA_BITS-1:0] cap_data
);

   localparam int TX_BITS = OP_BITS + ADDR_BITS;
   localparam int FRAME   = TX_BITS + DATA_BITS;
   localparam int BW      = $clog2(FRAME + 1);

   phase_e               st_q, st_n;
   logic [BW-1:0]        bits_q;
   logic [TX_BITS-1:0]   tx_q;
   logic [DATA_BITS-1:0] rx_q;
   logic                 unused_rsvd;

   assign unused_rsvd = ^cfg.rsvd;

   always_comb begin
      st_n     = st_q;
      t_load   = 1'b0;
      t_len    = at_least_one(cfg.cs_lead);
      done_clr = 1'b0;
      cap_we   = 1'b0;
      case (st_q)
         PH_IDLE: if (cfg.start) begin
            st_n   = PH_LEAD;
            t_load = 1'b1;
            t_len  = at_least_one(cfg.cs_lead);
         end
         PH_LEAD: if (t_last) begin
            st_n   = PH_LOW;
            t_load = 1'b1;
            t_len  = at_least_one(cfg.sck_lo);
         end
         PH_LOW: if (t_last) begin
            st_n   = PH_HIGH;
            t_load = 1'b1;
            t_len  = at_least_one(cfg.sck_hi);
         end
         PH_HIGH: if (t_last) begin
            t_load = 1'b1;
            if (bits_q == BW'(FRAME - 1)) begin
               st_n  = PH_TAIL;
               t_len = at_least_one(cfg.cs_tail);
            end else begin
               st_n  = PH_LOW;
               t_len = at_least_one(cfg.sck_lo);
            end
         end
         PH_TAIL: if (t_last) begin
            st_n     = PH_GAP;
            t_load   = 1'b1;
            t_len    = at_least_one(cfg.cs_gap);
            cap_we   = 1'b1;
            done_clr = ~cfg.wait_rdy;
         end
         PH_GAP: if (t_last) begin
            st_n     = PH_IDLE;
            done_clr = cfg.wait_rdy;
         end
         default: st_n = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= PH_IDLE;
         bits_q <= '0;
         tx_q   <= '0;
         rx_q   <= '0;
      end else begin
         st_q <= st_n;
         if (st_q == PH_IDLE && cfg.start) begin
            tx_q   <= {opcode, flash_addr};
            bits_q <= '0;
         end
         if (st_q == PH_LOW && t_last && bits_q >= BW'(TX_BITS)) begin
            rx_q <= {rx_q[DATA_BITS-2:0], miso};
         end
         if (st_q == PH_HIGH && t_last) begin
            bits_q <= bits_q + 1'b1;
            tx_q   <= {tx_q[TX_BITS-2:0], 1'b0};
         end
      end
   end

   assign cs_n     = !(st_q == PH_LEAD || st_q == PH_LOW || st_q == PH_HIGH || st_q == PH_TAIL);
   assign sck      = (st_q == PH_HIGH);
   assign mosi     = (st_q == PH_LOW || st_q == PH_HIGH) && (bits_q < BW'(TX_BITS)) ?
                     tx_q[TX_BITS-1] : 1'b0;
   assign eng_busy = (st_q != PH_IDLE);
   assign cap_data = rx_q;

   // R2: outgoing bit holds steady through a clock-high phase
   p_mosi_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck)) |-> $stable(mosi));

   // R3: the tail is entered only after every frame bit was clocked
   p_frame_complete_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PH_TAIL) |-> (bits_q == BW'(FRAME)));

   // R2: clock never pulses with chip select released
   p_sck_within_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck) |-> !cs_n);

endmodule

// File: rtl/spi_word_reader.sv
`timescale 1ns/1ps
module spi_word_reader
   import spi_rd_pkg::*;
#(
   parameter int ADDR_BITS = 24,
   parameter int DATA_BITS = 32,
   parameter int OP_BITS   = 8,
   parameter int READ_SLOT = 1,
   parameter logic [OP_BITS-1:0] READ_OPCODE = 8'h03
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [REG_AW-1:0] rd_addr,
   output logic [31:0]       rd_data,
   output logic              spi_cs_n,
   output logic              spi_sck,
   output logic              spi_mosi,
   input  logic              spi_miso
);

   if (ADDR_BITS < 2 || ADDR_BITS > 32) begin : g_bad_addr
      $error("ADDR_BITS must lie in 2..32");
   end
   if (DATA_BITS < 2 || DATA_BITS > 32) begin : g_bad_data
      $error("DATA_BITS must lie in 2..32");
   end
   if (OP_BITS < 1 || OP_BITS > 32) begin : g_bad_op
      $error("OP_BITS must lie in 1..32");
   end
   if (READ_SLOT < 0 || READ_SLOT >= NUM_OPS) begin : g_bad_slot
      $error("READ_SLOT outside the opcode file");
   end
   if (SEL_W >= REG_AW || RSVD_W < 0) begin : g_bad_map
      $error("control or address map does not fit");
   end

   ctrl_t                 cfg;
   logic [ADDR_BITS-1:0]  flash_addr;
   logic [OP_BITS-1:0]    opcode;
   logic                  eng_busy;
   logic                  done_clr;
   logic                  cap_we;
   logic [DATA_BITS-1:0]  cap_data;
   logic                  t_load;
   logic [TW-1:0]         t_len;
   logic                  t_last;
   logic                  t_empty;

   spi_rd_regs #(
      .ADDR_BITS  (ADDR_BITS),
      .DATA_BITS  (DATA_BITS),
      .OP_BITS    (OP_BITS),
      .READ_SLOT  (READ_SLOT),
      .READ_OPCODE(READ_OPCODE)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .rd_addr    (rd_addr),
      .rd_data    (rd_data),
      .eng_busy   (eng_busy),
      .done_clr   (done_clr),
      .cap_we     (cap_we),
      .cap_data   (cap_data),
      .cfg        (cfg),
      .flash_addr (flash_addr),
      .opcode     (opcode)
   );

   spi_rd_timer #(.TW(TW)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (t_load),
      .len   (t_len),
      .last  (t_last),
      .empty (t_empty)
   );

   spi_rd_seq #(
      .ADDR_BITS(ADDR_BITS),
      .DATA_BITS(DATA_BITS),
      .OP_BITS  (OP_BITS)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg        (cfg),
      .opcode     (opcode),
      .flash_addr (flash_addr),
      .miso       (spi_miso),
      .t_last     (t_last),
      .t_load     (t_load),
      .t_len      (t_len),
      .cs_n       (spi_cs_n),
      .sck        (spi_sck),
      .mosi       (spi_mosi),
      .eng_busy   (eng_busy),
      .done_clr   (done_clr),
      .cap_we     (cap_we),
      .cap_data   (cap_data)
   );

   // R3: every active phase has a live countdown behind it
   p_timer_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
      eng_busy |-> !t_empty);

   // R5: a launch drops chip select on the very next edge
   p_launch_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!eng_busy && cfg.start) |=> !spi_cs_n);

endmodule

// File: tb/tb_spi_word_reader.sv
`timescale 1ns/1ps
module tb_spi_word_reader;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        spi_cs_n, spi_sck, spi_mosi;
   logic        spi_miso = 1'b0;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   spi_word_reader dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso)
   );

   function automatic logic [31:0] flash_word(input logic [23:0] a);
      return {a[7:0], a} ^ 32'h9E3779B9;
   endfunction

   function automatic int eff(input logic [3:0] v);
      return (v == 4'd0) ? 1 : int'(v);
   endfunction

   function automatic logic [31:0] mk_ctrl(input logic [3:0] lead, hi, lo, tail, gap,
                                           input logic [2:0] sel, input bit wrdy, input bit go);
      return {go, 7'd0, wrdy, sel, gap, tail, lo, hi, lead};
   endfunction

   // flash model, mode 0
   logic [31:0] m_in = '0;
   logic [31:0] m_word = '0;
   int          m_cnt = 0;

   always @(negedge spi_cs_n) begin
      m_cnt = 0;
      m_in  = '0;
   end
   always @(posedge spi_sck) begin
      if (m_cnt < 32) m_in = {m_in[30:0], spi_mosi};
      m_cnt++;
      if (m_cnt == 32) m_word = flash_word(m_in[23:0]);
   end
   always @(negedge spi_sck) begin
      if (!spi_cs_n && m_cnt >= 32 && m_cnt < 64) spi_miso = m_word[63 - m_cnt];
   end

   // waveform monitor
   int cs_low_cnt = 0, pre_cnt = 0, hi_cnt = 0, post_cnt = 0, rise_cnt = 0;
   int gap_cnt = 0, last_gap = 0;
   bit seen_rise = 0, prev_cs = 1, prev_sck = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_cs && !spi_cs_n) begin
            cs_low_cnt = 0; pre_cnt = 0; hi_cnt = 0; post_cnt = 0; rise_cnt = 0;
            seen_rise = 0; last_gap = gap_cnt; gap_cnt = 0;
         end
         if (!spi_cs_n) begin
            cs_low_cnt++;
            if (spi_sck) hi_cnt++;
            if (spi_sck && !prev_sck) rise_cnt++;
            if (spi_sck) seen_rise = 1;
            if (!spi_sck && !seen_rise) pre_cnt++;
            if (!spi_sck && m_cnt == 64) post_cnt++;
         end else begin
            gap_cnt++;
         end
         prev_cs  = spi_cs_n;
         prev_sck = spi_sck;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      wr_addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      #0.5;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      rd_addr = a;
      #0.2;
      d = rd_data;
   endtask

   task automatic wait_done(output int guard);
      logic [31:0] v;
      guard = 0;
      do begin
         @(negedge clk); #0.5;
         rd(4'd1, v);
         guard++;
      end while (v[31] && guard < 5000);
   endtask

   logic [7:0] exp_op [8];

   task automatic run_xfer(input logic [23:0] a, input logic [3:0] lead, hi, lo, tail, gap,
                           input logic [2:0] sel, input bit wrdy);
      logic [31:0] cfg, v;
      int guard;
      cfg = mk_ctrl(lead, hi, lo, tail, gap, sel, wrdy, 1'b0);
      wr(4'd0, {8'd0, a});
      wr(4'd1, cfg);
      wr(4'd1, cfg | 32'h8000_0000);
      rd(4'd1, v);
      chk("R5 start set after launch write", {31'd0, v[31]}, 32'd1);
      chk("R5 cs still high on launch cycle", {31'd0, spi_cs_n}, 32'd1);
      @(negedge clk); #0.5;
      chk("R5 cs low one edge later", {31'd0, spi_cs_n}, 32'd0);
      wr(4'd0, {8'd0, ~a});
      wait_done(guard);
      chk("R6 transfer completes", {31'd0, guard < 5000}, 32'd1);
      chk("R6 cs-high cycles when start clears", gap_cnt, wrdy ? eff(gap) + 1 : 1);
      rd(4'd2, v);
      chk("R7 data word", v, flash_word(a));
      chk("R2 command byte", {24'd0, m_in[31:24]}, {24'd0, exp_op[sel]});
      chk("R2 address bits", {8'd0, m_in[23:0]}, {8'd0, a});
      chk("R3 cs low length", cs_low_cnt, eff(lead) + 64 * (eff(lo) + eff(hi)) + eff(tail));
      chk("R3 lead to first rise", pre_cnt, eff(lead) + eff(lo));
      chk("R3 total clock high", hi_cnt, 64 * eff(hi));
      chk("R3 rise count", rise_cnt, 64);
      chk("R3 tail length", post_cnt, eff(tail));
      rd(4'd0, v);
      chk("R8 address write while busy ignored", v, {8'd0, a});
      if (!wrdy) repeat (eff(gap) + 1) @(negedge clk);
      #0.5;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int guard;
      void'($urandom(32'd2024));
      for (int i = 0; i < 8; i++) exp_op[i] = 8'h00;
      exp_op[1] = 8'h03;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #0.5;

      // R1 reset state
      chk("R1 cs idle", {31'd0, spi_cs_n}, 32'd1);
      chk("R1 sck idle", {31'd0, spi_sck}, 32'd0);
      rd(4'd1, v); chk("R1 control reset", v, 32'h0013_2222);
      rd(4'd9, v); chk("R1 read slot", v, 32'h03);
      rd(4'd8, v); chk("R1 slot 0", v, 32'h0);
      rd(4'd0, v); chk("R1 address reset", v, 32'h0);
      rd(4'd2, v); chk("R1 data reset", v, 32'h0);

      // R10 opcode file
      wr(4'd13, 32'h0000_000B); exp_op[5] = 8'h0B;
      rd(4'd13, v); chk("R10 slot 5 readback", v, 32'h0B);

      // default timing
      run_xfer(24'hA5_3C_0F, 4'd2, 4'd2, 4'd2, 4'd2, 4'd3, 3'd1, 1'b0);
      // R4 all-zero durations
      run_xfer(24'h12_34_56, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 3'd1, 1'b0);
      // R10 alternate opcode with wait-ready
      run_xfer(24'hFF_00_81, 4'd3, 4'd1, 4'd4, 4'd5, 4'd6, 3'd5, 1'b1);

      // R7 data clear while idle
      wr(4'd2, 32'h0);
      rd(4'd2, v); chk("R7 data register cleared", v, 32'h0);

      // random mix
      for (int k = 0; k < 8; k++) begin
         logic [23:0] a;
         logic [3:0] f0, f1, f2, f3, f4;
         a  = 24'($urandom);
         f0 = 4'($urandom); f1 = 4'($urandom % 5); f2 = 4'($urandom % 5);
         f3 = 4'($urandom); f4 = 4'($urandom);
         run_xfer(a, f0, f1, f2, f3, f4, ($urandom % 2) ? 3'd5 : 3'd1, 1'($urandom));
      end

      // R9 / R8: start written every cycle across completion and gap
      for (int m = 0; m < 2; m++) begin
         logic [31:0] cfg;
         bit wrdy;
         wrdy = (m == 1);
         cfg = mk_ctrl(4'd1, 4'd1, 4'd1, 4'd1, 4'd9, 3'd1, wrdy, 1'b1);
         wr(4'd0, 32'h0000_4321);
         wr(4'd1, cfg);
         wait_done(guard);
         chk("R6 first back-to-back frame done", {31'd0, guard < 5000}, 32'd1);
         rd(4'd1, v);
         chk("R8 start stays clear inside gap", {31'd0, v[31]}, 32'd0);
         guard = 0;
         while (spi_cs_n && guard < 100) begin
            wr(4'd1, cfg);
            guard++;
         end
         chk("R9 gap before relaunch", last_gap, wrdy ? 9 + 2 : 9 + 2);
         wait_done(guard);
         rd(4'd2, v);
         chk("R7 relaunched frame data", v, flash_word(24'h004321));
         repeat (12) @(negedge clk);
         #0.5;
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule